// File: doc/BRIEF.md
# Dual-Channel PWM Compare Timer

A single timer channel with one counter and two compare outputs, A and B. The counter runs in one of three counting kinds: non-PWM (a free run over the full range, or a clear-on-match run up to a programmable TOP), single-slope fast PWM, or dual-slope phase-correct PWM. A four-bit mode select picks the counting kind and the TOP source. Each output has its own two-bit action field. The meaning of that field depends on the counting kind, so one field value can clear, set or toggle the pin, or leave it disconnected.

The compare values, TOP, mode, action fields and force strobes are register-style inputs that a host drives directly. The outputs are the two waveform pins and a per-pin flag that shows whether the waveform logic currently owns the pin. Every pin change is registered. A pin changes on the clock edge at which the counter holds the value that causes the change, so it becomes visible one cycle after the counter shows that value.

Top module: `pwm_cmp_timer`

## Requirements
- R1: Action field 00 disconnects the pin in every counting kind. The connect flag reads 0 one cycle later, and the pin keeps its last level for as long as it is disconnected.
- R2: The mode select decodes as follows. Values 5, 6, 7 and 15 give fast PWM. Values 1, 2, 3, 8, 9, 10, 11 and 14 give phase-correct PWM. All other values give non-PWM. Modes 0 and 13 use TOP = all ones; every other mode uses the TOP input, which must be at least 1. Non-PWM and fast PWM count up and wrap from TOP to 0. Phase-correct counts up to TOP, then down to 0, and reverses at each end.
- R3: In fast PWM, field 10 clears the pin on a compare match and sets it at BOTTOM (count 0). Field 11 sets the pin on a match and clears it at BOTTOM.
- R4: In fast PWM, field 01 toggles pin A on a match only when the mode select is 15. Pin B is always disconnected with 01, and pin A is disconnected with 01 in every other fast mode.
- R5: In phase-correct PWM, field 10 clears the pin on a match while the slope is up and sets it on a match while the slope is down. Field 11 does the reverse. The slope is taken as up at count 0, as down at TOP, and as the counting direction elsewhere.
- R6: In phase-correct PWM, field 01 toggles pin A on a match only for mode select 9 or 14. Pin B is disconnected with 01.
- R7: In both PWM kinds, with the field's high bit set and the active compare value equal to TOP, the match is ignored. At BOTTOM the pin is set for field 10 and cleared for field 11.
- R8: In non-PWM, a match toggles the pin for field 01, clears it for 10 and sets it for 11.
- R9: In non-PWM, a force strobe applies the channel's field action as if a match had occurred, and it leaves the counter sequence unchanged. In PWM kinds the strobes have no effect.
- R10: In PWM kinds, the active compare value loads from the compare input only on the edge at which the counter is at TOP. In non-PWM it loads on every edge.
- R11: After an asynchronous reset the counter is 0, the direction is up, both pins are 0 and both connect flags are 0. The active compare values are also 0.
- R12: In fast PWM, when a match and BOTTOM coincide (compare value 0), the match action wins.
- R13: A pin changes on the edge at which the counter holds the triggering value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Mode select (counting kind and TOP source) |
| top_i | input | W | Programmable TOP |
| cmp_a_i | input | W | Compare value, channel A |
| cmp_b_i | input | W | Compare value, channel B |
| act_a_i | input | 2 | Action field, channel A |
| act_b_i | input | 2 | Action field, channel B |
| force_a_i | input | 1 | Force-compare strobe, channel A |
| force_b_i | input | 1 | Force-compare strobe, channel B |
| wave_a_o | output | 1 | Waveform pin A |
| wave_b_o | output | 1 | Waveform pin B |
| en_a_o | output | 1 | Pin A connected to waveform logic |
| en_b_o | output | 1 | Pin B connected to waveform logic |

## Verification
The sweep exercises compare values of 0 and of TOP. A compare value of TOP catches a design that keeps acting on the ignored match, which would leave a spurious pulse at the turn-around. A compare value of 0 catches a fast-PWM design whose BOTTOM action beats the match, which would give a full-duty pin instead of a silent one. The toggle-only mode selects are swept against their neighbours, so a design that toggles B, or toggles in the wrong mode, shows up as a wrong connect flag or an extra edge. Changing the compare value mid-run catches a design that skips double buffering: its duty cycle would change before TOP. Force strobes land in every counting kind, which catches a design that honours them in PWM or lets them disturb the counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {K_NONPWM, K_FAST, K_PHASE} kind_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR, ACT_TGL} act_e;

  function automatic kind_e kind_of(input logic [3:0] m);
    case (m)
      4'd5, 4'd6, 4'd7, 4'd15: kind_of = K_FAST;
      4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd14: kind_of = K_PHASE;
      default: kind_of = K_NONPWM;
    endcase
  endfunction

  function automatic logic full_range(input logic [3:0] m);
    full_range = (m == 4'd0) || (m == 4'd13);
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  kind_e        kind_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         at_top_o,
  output logic         at_bot_o,
  output logic         slope_up_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  assign cnt_o      = cnt_q;
  assign at_top_o   = (cnt_q == top_i);
  assign at_bot_o   = (cnt_q == '0);
  // extremes fix the slope regardless of the stored direction
  assign slope_up_o = at_bot_o ? 1'b1 : (at_top_o ? 1'b0 : up_q);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (kind_i == K_PHASE) begin
      if (up_q) begin
        if (cnt_q >= top_i) begin
          up_d  = 1'b0;
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else begin
      up_d  = 1'b1;
      cnt_d = (cnt_q >= top_i) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int W    = 16,
  parameter bit IS_A = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  kind_e        kind_i,
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] cmp_i,
  input  logic [1:0]   act_i,
  input  logic         force_i,
  input  logic [W-1:0] cnt_i,
  input  logic         at_top_i,
  input  logic         at_bot_i,
  input  logic         slope_up_i,
  output logic         wave_o,
  output logic         en_o
);
  logic [W-1:0] ocr_q;
  logic         match, excl, conn, load;
  act_e         act;
  logic         pin_q, en_q;

  assign match = (cnt_i == ocr_q);
  assign excl  = (ocr_q == top_i);
  assign load  = (kind_i == K_NONPWM) || at_top_i;

  always_comb begin
    conn = 1'b0;
    act  = ACT_NONE;
    case (kind_i)
      K_NONPWM: begin
        conn = (act_i != 2'b00);
        if (conn && (match || force_i)) begin
          case (act_i)
            2'b01:   act = ACT_TGL;
            2'b10:   act = ACT_CLR;
            default: act = ACT_SET;
          endcase
        end
      end
      K_FAST: begin
        if (act_i == 2'b01) begin
          conn = IS_A && (mode_i == 4'd15);
          if (conn && match) act = ACT_TGL;
        end else if (act_i[1]) begin
          conn = 1'b1;
          // match beats BOTTOM; match at TOP is dropped
          if (match && !excl)  act = act_i[0] ? ACT_SET : ACT_CLR;
          else if (at_bot_i)   act = act_i[0] ? ACT_CLR : ACT_SET;
        end
      end
      K_PHASE: begin
        if (act_i == 2'b01) begin
          conn = IS_A && ((mode_i == 4'd9) || (mode_i == 4'd14));
          if (conn && match) act = ACT_TGL;
        end else if (act_i[1]) begin
          conn = 1'b1;
          if (match && !excl)
            act = (slope_up_i ^ act_i[0]) ? ACT_CLR : ACT_SET;
          else if (excl && at_bot_i)
            act = act_i[0] ? ACT_CLR : ACT_SET;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q <= '0;
      pin_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (load) ocr_q <= cmp_i;
      en_q <= conn;
      case (act)
        ACT_SET: pin_q <= 1'b1;
        ACT_CLR: pin_q <= 1'b0;
        ACT_TGL: pin_q <= ~pin_q;
        default: ;
      endcase
    end
  end

  assign wave_o = pin_q;
  assign en_o   = en_q;
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic [1:0]   act_a_i,
  input  logic [1:0]   act_b_i,
  input  logic         force_a_i,
  input  logic         force_b_i,
  output logic         wave_a_o,
  output logic         wave_b_o,
  output logic         en_a_o,
  output logic         en_b_o
);
  localparam int NCH = 2;

  kind_e        kind_w;
  logic [W-1:0] etop_w, cnt_w;
  logic         at_top_w, at_bot_w, slope_w;
  logic [W-1:0] cmp_w   [NCH];
  logic [1:0]   act_w   [NCH];
  logic         frc_w   [NCH];
  logic         wave_w  [NCH];
  logic         en_w    [NCH];

  assign kind_w = kind_of(mode_i);
  assign etop_w = full_range(mode_i) ? {W{1'b1}} : top_i;

  assign cmp_w[0] = cmp_a_i;
  assign cmp_w[1] = cmp_b_i;
  assign act_w[0] = act_a_i;
  assign act_w[1] = act_b_i;
  assign frc_w[0] = force_a_i;
  assign frc_w[1] = force_b_i;

  pwm_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind_w),
    .top_i      (etop_w),
    .cnt_o      (cnt_w),
    .at_top_o   (at_top_w),
    .at_bot_o   (at_bot_w),
    .slope_up_o (slope_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.W(W), .IS_A(i == 0)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .kind_i     (kind_w),
      .mode_i     (mode_i),
      .top_i      (etop_w),
      .cmp_i      (cmp_w[i]),
      .act_i      (act_w[i]),
      .force_i    (frc_w[i]),
      .cnt_i      (cnt_w),
      .at_top_i   (at_top_w),
      .at_bot_i   (at_bot_w),
      .slope_up_i (slope_w),
      .wave_o     (wave_w[i]),
      .en_o       (en_w[i])
    );
  end

  assign wave_a_o = wave_w[0];
  assign wave_b_o = wave_w[1];
  assign en_a_o   = en_w[0];
  assign en_b_o   = en_w[1];
endmodule

// File: rtl/pwm_cmp_timer_chk.sv
module pwm_cmp_timer_chk
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   mode_i,
  input logic [W-1:0] top_i,
  input logic [1:0]   act_a_i,
  input logic [1:0]   act_b_i,
  input logic         force_a_i,
  input logic         wave_a_o,
  input logic         wave_b_o,
  input logic         en_a_o,
  input logic         en_b_o,
  input logic [W-1:0] cnt_i
);
  logic [W-1:0] etop;
  assign etop = full_range(mode_i) ? {W{1'b1}} : top_i;

  p_off_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_a_i == 2'b00) |=> !en_a_o);
  p_hold_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_a_o |-> $stable(wave_a_o));
  p_hold_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_b_o |-> $stable(wave_b_o));
  p_fast_b_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_of(mode_i) == K_FAST && act_b_i == 2'b01) |=> !en_b_o);
  p_fast_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_of(mode_i) == K_FAST && cnt_i == top_i) |=> (cnt_i == '0));
  p_phase_turn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_of(mode_i) == K_PHASE && cnt_i == '0 && top_i != '0) |=> (cnt_i == 1));
  p_force_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_of(mode_i) == K_NONPWM && force_a_i && cnt_i != etop)
      |=> (cnt_i == $past(cnt_i) + 1'b1));
endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .top_i     (top_i),
  .act_a_i   (act_a_i),
  .act_b_i   (act_b_i),
  .force_a_i (force_a_i),
  .wave_a_o  (wave_a_o),
  .wave_b_o  (wave_b_o),
  .en_a_o    (en_a_o),
  .en_b_o    (en_b_o),
  .cnt_i     (cnt_w)
);

// File: tb/pwm_cmp_timer_test.sv
module pwm_cmp_timer_test;
  localparam int W    = 4;
  localparam int FULL = (1 << W) - 1;
  localparam int RUN  = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]   mode;
  logic [W-1:0] top, cmp_a, cmp_b;
  logic [1:0]   act_a, act_b;
  logic         frc_a, frc_b;
  logic         wave_a, wave_b, en_a, en_b;

  int total = 0;
  int bad   = 0;

  int    m_cnt;
  bit    m_up;
  bit    m_pin [2];
  bit    m_en  [2];
  int    m_ocr [2];
  string m_tag [2];

  pwm_cmp_timer #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .top_i(top),
    .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .act_a_i(act_a), .act_b_i(act_b),
    .force_a_i(frc_a), .force_b_i(frc_b),
    .wave_a_o(wave_a), .wave_b_o(wave_b), .en_a_o(en_a), .en_b_o(en_b)
  );

  // 0 non-PWM, 1 fast, 2 phase-correct (R2 map)
  function automatic int bkind(input int md);
    if (md == 5 || md == 6 || md == 7 || md == 15) return 1;
    if ((md >= 1 && md <= 3) || (md >= 8 && md <= 11) || md == 14) return 2;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_up = 1'b1;
    for (int ch = 0; ch < 2; ch++) begin
      m_pin[ch] = 1'b0; m_en[ch] = 1'b0; m_ocr[ch] = 0; m_tag[ch] = "R11";
    end
  endtask

  // next state at the coming edge, from current model state and driven inputs
  task automatic model_step();
    int k, et, n_cnt, a, o, cv;
    bit n_up, at_t, at_b, slope, hit, f;
    bit n_pin [2];
    bit n_en  [2];
    int n_ocr [2];
    k  = bkind(int'(mode));
    et = (mode == 0 || mode == 13) ? FULL : int'(top);
    at_t  = (m_cnt == et);
    at_b  = (m_cnt == 0);
    slope = at_b ? 1'b1 : (at_t ? 1'b0 : m_up);
    for (int ch = 0; ch < 2; ch++) begin
      a  = (ch == 0) ? int'(act_a) : int'(act_b);
      cv = (ch == 0) ? int'(cmp_a) : int'(cmp_b);
      f  = (ch == 0) ? frc_a : frc_b;
      o  = m_ocr[ch];
      hit = (m_cnt == o);
      n_pin[ch] = m_pin[ch];
      n_en[ch]  = 1'b0;
      if (a == 0) m_tag[ch] = "R1";
      else if (k == 0) begin
        n_en[ch] = 1'b1;
        m_tag[ch] = f ? "R9" : "R8";
        if (hit || f) n_pin[ch] = (a == 1) ? !m_pin[ch] : (a == 3);
      end else if (a == 1) begin
        n_en[ch] = (ch == 0) && ((k == 1) ? (mode == 15) : (mode == 9 || mode == 14));
        m_tag[ch] = (k == 1) ? "R4" : "R6";
        if (n_en[ch] && hit) n_pin[ch] = !m_pin[ch];
      end else begin
        n_en[ch] = 1'b1;
        m_tag[ch] = (o == et) ? "R7" : ((k == 1) ? "R3" : "R5");
        if (hit && o != et) n_pin[ch] = (k == 1) ? (a == 3) : ((a == 2) ? !slope : slope);
        else if (at_b && (k == 1 || o == et)) n_pin[ch] = (a == 2);
      end
      n_ocr[ch] = (k == 0 || at_t) ? cv : o;
    end
    if (k == 2) begin
      if (m_up) begin
        if (m_cnt >= et) begin n_up = 1'b0; n_cnt = m_cnt - 1; end
        else begin n_up = 1'b1; n_cnt = m_cnt + 1; end
      end else if (m_cnt == 0) begin n_up = 1'b1; n_cnt = 1; end
      else begin n_up = 1'b0; n_cnt = m_cnt - 1; end
    end else begin
      n_up = 1'b1;
      n_cnt = (m_cnt >= et) ? 0 : m_cnt + 1;
    end
    m_cnt = n_cnt; m_up = n_up;
    for (int ch = 0; ch < 2; ch++) begin
      m_pin[ch] = n_pin[ch]; m_en[ch] = n_en[ch]; m_ocr[ch] = n_ocr[ch];
    end
  endtask

  task automatic compare();
    check(m_tag[0], "wave_a", int'(wave_a), int'(m_pin[0]));
    check(m_tag[1], "wave_b", int'(wave_b), int'(m_pin[1]));
    check(m_tag[0], "en_a", int'(en_a), int'(m_en[0]));
    check(m_tag[1], "en_b", int'(en_b), int'(m_en[1]));
  endtask

  // cycle-exact comparison also covers R2 counter shape, R10 buffering,
  // R12 match-vs-BOTTOM priority and R13 edge timing
  task automatic run(input int md, input int aa, input int ab,
                     input int a0, input int b0, input int a1, input int b1);
    @(negedge clk);
    rst_n = 1'b0;
    mode = 4'(md); top = W'(6);
    cmp_a = W'(a0); cmp_b = W'(b0);
    act_a = 2'(aa); act_b = 2'(ab);
    frc_a = 1'b0; frc_b = 1'b0;
    model_reset();
    @(negedge clk);
    check("R11", "reset wave_a", int'(wave_a), 0);
    check("R11", "reset wave_b", int'(wave_b), 0);
    check("R11", "reset en_a", int'(en_a), 0);
    check("R11", "reset en_b", int'(en_b), 0);
    rst_n = 1'b1;
    for (int c = 0; c < RUN; c++) begin
      if (c == 20) begin cmp_a = W'(a1); cmp_b = W'(b1); end
      frc_a = (c % 7 == 3);
      frc_b = (c % 5 == 1);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  int modes [9] = '{0, 4, 12, 13, 5, 15, 1, 9, 14};
  int cfg [3][4] = '{'{2, 4, 6, 0}, '{6, 6, 3, 1}, '{0, 3, 2, 6}};

  initial begin
    for (int mi = 0; mi < 9; mi++)
      for (int aa = 0; aa < 4; aa++)
        for (int ab = 0; ab < 4; ab++)
          for (int ci = 0; ci < 3; ci++)
            run(modes[mi], aa, ab, cfg[ci][0], cfg[ci][1], cfg[ci][2], cfg[ci][3]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule